// File: doc/BRIEF.md
# Small Simple Dual-Port Distributed RAM

This block is a compact storage array of 32 words, each 20 bits wide. It has one write-only port and one read-only port. Each port has its own clock, so the block can pass words between two clock domains or act as a shallow delay line or buffer inside one domain. Each word is split into two 10-bit lanes, and a write can update either lane alone. Each port also has an address stall input. While the stall input is low, the port keeps using the address it last captured.

A parameter selects how the read port works. In the registered form, a word is loaded into an output register on the read clock. That register powers up at zero and has a clear input. In the flow-through form, the read data follows the read address with no clock at all, and it shows the array contents from power-up onwards. A second parameter sets what a registered read returns when it hits the word being written on the same edge: the new word, the old word, or an undefined value. The ports are plain memory ports with no handshake. A write or read happens on every enabled edge, and nothing is held back.

Top module: `lut_sdp_ram`

## Requirements
- R1: The array holds 32 independent 20-bit words. Every address keeps whatever was last written to it, and every address can be read back.
- R2: A write takes effect on the rising edge of `wclk` only while `wr_en` is high. With `wr_en` low, no word changes.
- R3: `wr_lane_en[0]` selects bits 9:0 and `wr_lane_en[1]` selects bits 19:10. An enabled lane takes its bits from `wr_data`.
- R4: A lane whose enable bit is low keeps its previous contents during a write.
- R5: When `wr_addr_ce` is low, a write goes to the address captured at the last `wclk` edge where `wr_addr_ce` was high, and `wr_addr` is ignored. When `wr_addr_ce` is high, `wr_addr` is used directly and is also captured.
- R6: The read address stalls in the same way under `rd_addr_ce`. The stall applies on `rclk` edges, and it also applies to the flow-through output.
- R7: Registered form: on a rising `rclk` edge with `rd_oce` high, `rd_data` loads the word at the read address. With `rd_oce` low, `rd_data` holds its value.
- R8: Registered form: while `rd_clr` is high, `rd_data` is forced to zero at once, with no clock edge needed. The clear wins over a load.
- R9: At power-up, a registered `rd_data` is zero. A flow-through `rd_data` shows the array contents, which power up as all zeros.
- R10: Flow-through form: `rd_data` follows the read address and the array contents combinationally. A completed write shows up with no read clock edge.
- R11: Registered form with new-data mode: if a read and an enabled write hit the same address on the same shared clock edge, the output receives the written lanes merged with the unwritten lanes of the old word.
- R12: Registered form with old-data mode: in the same collision, the output receives the word as it was before the write.
- R13: Registered form with don't-care mode: a colliding read returns an undefined value. Reads that do not collide are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable |
| wr_lane_en | input | 2 | Lane write enables (bit 0 selects bits 9:0, bit 1 selects bits 19:10) |
| wr_addr | input | 5 | Write address |
| wr_addr_ce | input | 1 | Write address enable; low stalls the write address |
| wr_data | input | 20 | Write data |
| rclk | input | 1 | Read clock |
| rd_addr | input | 5 | Read address |
| rd_addr_ce | input | 1 | Read address enable; low stalls the read address |
| rd_oce | input | 1 | Output register load enable |
| rd_clr | input | 1 | Asynchronous clear of the output register |
| rd_data | output | 20 | Read data |

## Verification
The bench goes after the following corner cases, and each one traps a specific fault:
- Lane writes are swept over all four enable patterns. A lane decode that is swapped, or that is ignored, corrupts the lane that should have been kept.
- Both address stalls are exercised with a different address on the inputs while the stall is active. A design that leaks the live address writes to, or reads from, the wrong word.
- A same-address collision is compared across the new-data and old-data variants. A design that ignores the mode gives the same word in both.
- The clear is raised between clock edges. A synchronous clear would then still show stale data.
- The flow-through variant is checked right after each address change and right after a write. A hidden register in that path would lag by one cycle.

// File: rtl/lut_ram_pkg.sv
package lut_ram_pkg;
  typedef enum logic [1:0] {
    RDW_NEW      = 2'd0,
    RDW_OLD      = 2'd1,
    RDW_DONTCARE = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/lut_ram_addr_stall.sv
module lut_ram_addr_stall #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          ce,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_eff
);
  logic [AW-1:0] held = '0;

  always_ff @(posedge clk) begin
    if (ce) held <= addr_in;
  end

  assign addr_eff = ce ? addr_in : held;

  logic primed = 1'b0;
  always_ff @(posedge clk) primed <= 1'b1;

  // R5 on the write port, R6 on the read port
  p_stall_reuse_r5: assert property (@(posedge clk) disable iff (!primed)
    $past(ce) && !ce |-> addr_eff == $past(addr_in));
endmodule

// File: rtl/lut_ram_array.sv
module lut_ram_array #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 20,
  parameter int LANES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = WIDTH / LANES
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [LANES-1:0] lane_en,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rword
);
  logic [WIDTH-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge wclk) begin
    if (we) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
      end
    end
  end

  assign rword = mem[raddr];

  logic primed = 1'b0;
  always_ff @(posedge wclk) primed <= 1'b1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_lane_write_r3: assert property (@(posedge wclk) disable iff (!primed)
      we && lane_en[g] |=> mem[$past(waddr)][g*LW +: LW] == $past(wdata[g*LW +: LW]));
    p_lane_keep_r4: assert property (@(posedge wclk) disable iff (!primed)
      we && !lane_en[g] |=> mem[$past(waddr)][g*LW +: LW] == $past(rword_lane_snap(g)));
  end

  function automatic logic [LW-1:0] rword_lane_snap(input int lane);
    return mem[waddr][lane*LW +: LW];
  endfunction
endmodule

// File: rtl/lut_ram_rdpath.sv
module lut_ram_rdpath
  import lut_ram_pkg::*;
#(
  parameter int        WIDTH   = 20,
  parameter int        LANES   = 2,
  parameter int        AW      = 5,
  parameter bit        OUT_REG = 1'b1,
  parameter rdw_mode_e RDW     = RDW_NEW,
  localparam int LW = WIDTH / LANES
) (
  input  logic             rclk,
  input  logic             clr,
  input  logic             oce,
  input  logic [WIDTH-1:0] rword,
  input  logic [AW-1:0]    raddr,
  input  logic             we,
  input  logic [LANES-1:0] lane_en,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rd_data
);
  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] q = '0;
    logic             hit;
    logic [WIDTH-1:0] merged;
    logic [WIDTH-1:0] capture;

    always_comb begin
      hit    = we && (waddr == raddr);
      merged = rword;
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) merged[l*LW +: LW] = wdata[l*LW +: LW];
      end
      if (!hit) begin
        capture = rword;
      end else begin
        case (RDW)
          RDW_NEW: capture = merged;
          RDW_OLD: capture = rword;
          default: capture = 'x;
        endcase
      end
    end

    always_ff @(posedge rclk or posedge clr) begin
      if (clr)      q <= '0;
      else if (oce) q <= capture;
    end

    assign rd_data = q;

    logic primed = 1'b0;
    always_ff @(posedge rclk) primed <= 1'b1;

    p_clear_zero_r8: assert property (@(posedge rclk) disable iff (!primed)
      clr && $past(clr) |-> rd_data == '0);
    p_oce_hold_r7: assert property (@(posedge rclk) disable iff (!primed)
      !oce && !clr |=> clr || rd_data == $past(rd_data));
    p_plain_load_r7: assert property (@(posedge rclk) disable iff (!primed)
      oce && !clr && !hit |=> clr || rd_data == $past(rword));
    if (RDW == RDW_OLD) begin : g_old_chk
      p_old_word_r12: assert property (@(posedge rclk) disable iff (!primed)
        oce && !clr && hit |=> clr || rd_data == $past(rword));
    end
  end else begin : g_flow
    assign rd_data = rword;
  end
endmodule

// File: rtl/lut_sdp_ram.sv
module lut_sdp_ram
  import lut_ram_pkg::*;
#(
  parameter int        DEPTH    = 32,
  parameter int        WIDTH    = 20,
  parameter int        LANES    = 2,
  parameter bit        OUT_REG  = 1'b1,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_lane_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_addr_ce,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rclk,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_addr_ce,
  input  logic             rd_oce,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] rd_data
);
  logic [AW-1:0]    waddr_eff;
  logic [AW-1:0]    raddr_eff;
  logic [WIDTH-1:0] rword;

  lut_ram_addr_stall #(.AW(AW)) u_wstall (
    .clk(wclk), .ce(wr_addr_ce), .addr_in(wr_addr), .addr_eff(waddr_eff)
  );

  lut_ram_addr_stall #(.AW(AW)) u_rstall (
    .clk(rclk), .ce(rd_addr_ce), .addr_in(rd_addr), .addr_eff(raddr_eff)
  );

  lut_ram_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LANES(LANES)) u_array (
    .wclk(wclk), .we(wr_en), .lane_en(wr_lane_en), .waddr(waddr_eff),
    .wdata(wr_data), .raddr(raddr_eff), .rword(rword)
  );

  lut_ram_rdpath #(
    .WIDTH(WIDTH), .LANES(LANES), .AW(AW), .OUT_REG(OUT_REG), .RDW(RDW_MODE)
  ) u_rdpath (
    .rclk(rclk), .clr(rd_clr), .oce(rd_oce), .rword(rword), .raddr(raddr_eff),
    .we(wr_en), .lane_en(wr_lane_en), .waddr(waddr_eff), .wdata(wr_data),
    .rd_data(rd_data)
  );
endmodule

// File: tb/lut_sdp_ram_test.sv
module lut_sdp_ram_test;
  import lut_ram_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_lane_en = 2'b00;
  logic [4:0]  wr_addr = '0;
  logic        wr_addr_ce = 1'b0;
  logic [19:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic        rd_addr_ce = 1'b0;
  logic        rd_oce = 1'b0;
  logic        rd_clr = 1'b0;
  logic [19:0] q_new, q_old, q_dc, q_flow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [19:0] ref_m [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_sdp_ram #(.OUT_REG(1'b1), .RDW_MODE(RDW_NEW)) uut (
    .wclk(clk), .wr_en(wr_en), .wr_lane_en(wr_lane_en), .wr_addr(wr_addr),
    .wr_addr_ce(wr_addr_ce), .wr_data(wr_data), .rclk(clk), .rd_addr(rd_addr),
    .rd_addr_ce(rd_addr_ce), .rd_oce(rd_oce), .rd_clr(rd_clr), .rd_data(q_new));
  lut_sdp_ram #(.OUT_REG(1'b1), .RDW_MODE(RDW_OLD)) u_old (
    .wclk(clk), .wr_en(wr_en), .wr_lane_en(wr_lane_en), .wr_addr(wr_addr),
    .wr_addr_ce(wr_addr_ce), .wr_data(wr_data), .rclk(clk), .rd_addr(rd_addr),
    .rd_addr_ce(rd_addr_ce), .rd_oce(rd_oce), .rd_clr(rd_clr), .rd_data(q_old));
  lut_sdp_ram #(.OUT_REG(1'b1), .RDW_MODE(RDW_DONTCARE)) u_dc (
    .wclk(clk), .wr_en(wr_en), .wr_lane_en(wr_lane_en), .wr_addr(wr_addr),
    .wr_addr_ce(wr_addr_ce), .wr_data(wr_data), .rclk(clk), .rd_addr(rd_addr),
    .rd_addr_ce(rd_addr_ce), .rd_oce(rd_oce), .rd_clr(rd_clr), .rd_data(q_dc));
  lut_sdp_ram #(.OUT_REG(1'b0), .RDW_MODE(RDW_NEW)) u_flow (
    .wclk(clk), .wr_en(wr_en), .wr_lane_en(wr_lane_en), .wr_addr(wr_addr),
    .wr_addr_ce(wr_addr_ce), .wr_data(wr_data), .rclk(clk), .rd_addr(rd_addr),
    .rd_addr_ce(rd_addr_ce), .rd_oce(rd_oce), .rd_clr(rd_clr), .rd_data(q_flow));

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] merge(input logic [19:0] old, input logic [19:0] d,
                                        input logic [1:0] ln);
    logic [19:0] m = old;
    if (ln[0]) m[9:0] = d[9:0];
    if (ln[1]) m[19:10] = d[19:10];
    return m;
  endfunction

  task automatic do_write(input logic [4:0] a, input logic [19:0] d, input logic [1:0] ln);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_addr_ce = 1'b1; wr_data = d; wr_lane_en = ln;
    @(posedge clk);
    ref_m[a] = merge(ref_m[a], d, ln);
  endtask

  task automatic do_read(input logic [4:0] a, input string req);
    @(negedge clk);
    wr_en = 1'b0; rd_addr = a; rd_addr_ce = 1'b1; rd_oce = 1'b1; rd_clr = 1'b0;
    #1 chk({req, " R10 flow"}, q_flow, ref_m[a]);
    @(negedge clk);
    chk({req, " R7 new-inst"}, q_new, ref_m[a]);
    chk({req, " R7 old-inst"}, q_old, ref_m[a]);
    chk({req, " R13 dc-inst"}, q_dc, ref_m[a]);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] oldv, newv, keep3;
    for (int i = 0; i < 32; i++) ref_m[i] = '0;
    #1;
    chk("R9 registered power-up", q_new, 20'h0);
    chk("R9 flow power-up", q_flow, ref_m[0]);

    // R1: full sweep
    for (int a = 0; a < 32; a++)
      do_write(5'(a), 20'((a * 20'h1357 + 20'h0A5C5) ^ (a << 12)), 2'b11);
    for (int a = 0; a < 32; a++) do_read(5'(a), "R1");

    // R2: disabled write leaves the word alone
    @(negedge clk);
    wr_en = 1'b0; wr_addr = 5'd4; wr_addr_ce = 1'b1; wr_data = ~ref_m[4]; wr_lane_en = 2'b11;
    @(posedge clk);
    do_read(5'd4, "R2");

    // R3/R4: every lane pattern
    for (int a = 0; a < 32; a++)
      do_write(5'(a), 20'((a * 20'h2E1D) ^ 20'hF00F3), 2'(a));
    for (int a = 0; a < 32; a++) do_read(5'(a), "R3 R4");

    // R5: write address stall
    @(negedge clk);
    wr_en = 1'b0; wr_addr_ce = 1'b1; wr_addr = 5'd5;
    @(negedge clk);
    wr_en = 1'b1; wr_addr_ce = 1'b0; wr_addr = 5'd9; wr_data = 20'hABCDE; wr_lane_en = 2'b11;
    @(posedge clk);
    ref_m[5] = 20'hABCDE;
    do_read(5'd5, "R5");
    do_read(5'd9, "R5");

    // R6: read address stall
    ref_m[7] = ~ref_m[3];
    do_write(5'd7, ref_m[7], 2'b11);
    keep3 = ref_m[3];
    @(negedge clk);
    wr_en = 1'b0; rd_addr = 5'd3; rd_addr_ce = 1'b1; rd_oce = 1'b1;
    @(negedge clk);
    rd_addr_ce = 1'b0; rd_addr = 5'd7;
    #1 chk("R6 flow stall", q_flow, keep3);
    @(negedge clk);
    chk("R6 registered stall", q_new, keep3);

    // R7: output enable low holds
    rd_addr_ce = 1'b1; rd_addr = 5'd10; rd_oce = 1'b1;
    @(negedge clk);
    chk("R7 load", q_new, ref_m[10]);
    rd_oce = 1'b0; rd_addr = 5'd7;
    @(negedge clk);
    chk("R7 hold", q_new, ref_m[10]);

    // R8: asynchronous clear
    #2 rd_clr = 1'b1;
    #1 chk("R8 clear without edge", q_new, 20'h0);
    rd_oce = 1'b1;
    @(negedge clk);
    chk("R8 clear beats load", q_new, 20'h0);
    rd_clr = 1'b0;

    // R11/R12: same-address collision on a shared edge
    @(negedge clk);
    oldv = ref_m[12];
    newv = merge(oldv, ~oldv, 2'b01);
    wr_en = 1'b1; wr_addr_ce = 1'b1; wr_addr = 5'd12; wr_data = ~oldv; wr_lane_en = 2'b01;
    rd_addr = 5'd12; rd_addr_ce = 1'b1; rd_oce = 1'b1;
    @(posedge clk);
    ref_m[12] = newv;
    @(negedge clk);
    chk("R11 new data", q_new, newv);
    chk("R12 old data", q_old, oldv);
    chk("R10 flow after write", q_flow, newv);

    // R13: non-colliding read during a write elsewhere
    wr_en = 1'b1; wr_addr = 5'd20; wr_data = 20'h13579; wr_lane_en = 2'b11; rd_addr = 5'd13;
    @(posedge clk);
    ref_m[20] = 20'h13579;
    @(negedge clk);
    chk("R13 dc no collision", q_dc, ref_m[13]);
    chk("R13 new no collision", q_new, ref_m[13]);
    do_read(5'd12, "R13 recover");
    do_read(5'd20, "R1 late");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule